// File: doc/BRIEF.md
# Fixed-Priority Lock-Aware Bus Arbiter

This block decides which of several masters on a shared, multiplexed system bus may start the next bus cycle. Each master raises an active-low request; the arbiter answers with one active-low grant per master, and at most one of them is low at any time. Priority is fixed: master 0 outranks master 1, and so on down to the last master. The arbiter watches the shared active-low busy and lock lines. It moves a grant only while both are high, that is while the bus is free. During a cycle that is not locked, the lock line follows the busy line.

Masters use lock to chain several bus cycles, for example a read-modify-write. A master keeps its grant through such a chain for as long as no higher-priority master asks for the bus. If a higher-priority request appears while the bus is occupied, the current grant is removed on the next edge. The new master is served only once busy and lock have both returned high. When no master is requesting, the last grant stays parked on its holder. All decisions are registered on the rising clock edge.

Top module: `prio_lock_arbiter`

## Requirements
- R1: While reset is low, and on the first edge after it, every grant_n bit is high.
- R2: At most one grant_n bit is low in any cycle.
- R3: If busy_n and lock_n are both high and at least one req_n bit is low, then after the next rising edge the only low grant_n bit is the one with the lowest index among the low req_n bits.
- R4: If busy_n and lock_n are both high and no req_n bit is low, grant_n keeps its value across the next edge. The holder stays parked, and all-high stays all-high.
- R5: If busy_n or lock_n is low and no request has a lower index than the current grant holder, grant_n keeps its value across the next edge.
- R6: If busy_n or lock_n is low and a request has a lower index than the current grant holder, all grant_n bits are high after the next edge. They stay high while the bus remains occupied.
- R7: On the first edge where busy_n and lock_n are both high after a withdrawal, the pending request with the lowest index receives the grant.
- R8: A request from a master with a higher index than the holder does not move or remove the grant while busy_n or lock_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | N_MASTERS | Bus requests, active low, bit 0 has the highest priority |
| busy_n | input | 1 | Shared bus-busy line, active low |
| lock_n | input | 1 | Shared bus-lock line, active low |
| grant_n | output | N_MASTERS | Registered bus grants, active low, at most one low |

## Verification
Directed sequences cover three cases. In the first, a lower master holds the bus locked while a less urgent master asks, which shows that R8 leaves the grant alone. In the second, a more urgent master asks during the lock, which shows the withdrawal of R6 and the deferred handover of R7. The third combines an idle free bus with a full set of requests, which separates parking (R4) from priority selection (R3). Random stretches then drive request vectors with free and occupied bus states. These expose any ordering slip between neighbouring indices, and any grant that changes while the bus is occupied.

// File: rtl/prio_lock_arbiter_pkg.sv
package prio_lock_arbiter_pkg;

   typedef enum logic [1:0] {
      ARB_KEEP  = 2'd0,
      ARB_AWARD = 2'd1,
      ARB_DROP  = 2'd2
   } arb_step_e;

   localparam int unsigned ARB_MAX_MASTERS = 16;

endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
   parameter int unsigned N_MASTERS = 4
) (
   input  logic [N_MASTERS-1:0] req,
   output logic [N_MASTERS-1:0] pick,
   output logic                 any
);

   logic [N_MASTERS:0] seen;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N_MASTERS; i++) begin : g_slot
      assign pick[i]   = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end

   assign any = seen[N_MASTERS];

endmodule

// File: rtl/arb_outrank.sv
module arb_outrank #(
   parameter int unsigned N_MASTERS = 4
) (
   input  logic [N_MASTERS-1:0] req,
   input  logic [N_MASTERS-1:0] gnt,
   output logic                 outranked
);

   logic [N_MASTERS:0]   above;
   logic [N_MASTERS-1:0] hit;

   assign above[0] = 1'b0;

   for (genvar j = 0; j < N_MASTERS; j++) begin : g_rank
      assign above[j+1] = above[j] | req[j];
      assign hit[j]     = gnt[j] & above[j];
   end

   assign outranked = |hit;

endmodule

// File: rtl/arb_grant_ctl.sv
module arb_grant_ctl
   import prio_lock_arbiter_pkg::*;
#(
   parameter int unsigned N_MASTERS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_free,
   input  logic                 any_req,
   input  logic                 outranked,
   input  logic [N_MASTERS-1:0] pick,
   output logic [N_MASTERS-1:0] gnt
);

   arb_step_e step;

   always_comb begin
      step = ARB_KEEP;
      if (bus_free) begin
         if (any_req) step = ARB_AWARD;
      end else if (outranked) begin
         step = ARB_DROP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt <= '0;
      end else begin
         case (step)
            ARB_AWARD: gnt <= pick;
            ARB_DROP:  gnt <= '0;
            default:   gnt <= gnt;
         endcase
      end
   end

endmodule

// File: rtl/prio_lock_arbiter.sv
module prio_lock_arbiter #(
   parameter int unsigned N_MASTERS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MASTERS-1:0] req_n,
   input  logic                 busy_n,
   input  logic                 lock_n,
   output logic [N_MASTERS-1:0] grant_n
);

   if (N_MASTERS < 2 || N_MASTERS > prio_lock_arbiter_pkg::ARB_MAX_MASTERS) begin : g_bad_count
      $error("prio_lock_arbiter: N_MASTERS out of range");
   end

   logic [N_MASTERS-1:0] req;
   logic [N_MASTERS-1:0] pick;
   logic [N_MASTERS-1:0] gnt;
   logic                 any_req;
   logic                 outranked;
   logic                 bus_free;

   assign req      = ~req_n;
   assign bus_free = busy_n & lock_n;

   arb_prio_pick #(.N_MASTERS(N_MASTERS)) u_pick (
      .req  (req),
      .pick (pick),
      .any  (any_req)
   );

   arb_outrank #(.N_MASTERS(N_MASTERS)) u_rank (
      .req       (req),
      .gnt       (gnt),
      .outranked (outranked)
   );

   arb_grant_ctl #(.N_MASTERS(N_MASTERS)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_free  (bus_free),
      .any_req   (any_req),
      .outranked (outranked),
      .pick      (pick),
      .gnt       (gnt)
   );

   assign grant_n = ~gnt;

endmodule

// File: rtl/prio_lock_arbiter_chk.sv
module prio_lock_arbiter_chk #(
   parameter int unsigned N_MASTERS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N_MASTERS-1:0] req_n,
   input logic                 busy_n,
   input logic                 lock_n,
   input logic [N_MASTERS-1:0] grant_n
);

   logic [N_MASTERS-1:0] act;
   logic [N_MASTERS-1:0] lowest;
   logic                 free;
   logic                 beats_holder;

   assign act    = ~req_n;
   assign lowest = act & (~act + {{(N_MASTERS-1){1'b0}}, 1'b1});
   assign free   = busy_n & lock_n;

   always_comb begin
      beats_holder = 1'b0;
      for (int j = 0; j < N_MASTERS; j++) begin
         for (int i = 0; i < j; i++) begin
            if (!grant_n[j] && act[i]) beats_holder = 1'b1;
         end
      end
   end

   p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~grant_n));

   p_pick_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (free && (|act)) |=> (~grant_n == $past(lowest)));

   p_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (free && !(|act)) |=> $stable(grant_n));

   p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!free && !beats_holder) |=> $stable(grant_n));

   p_withdraw_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!free && beats_holder) |=> (&grant_n));

endmodule

bind prio_lock_arbiter prio_lock_arbiter_chk #(.N_MASTERS(N_MASTERS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .req_n   (req_n),
   .busy_n  (busy_n),
   .lock_n  (lock_n),
   .grant_n (grant_n)
);

// File: tb/sim_prio_lock_arbiter.sv
module sim_prio_lock_arbiter;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req_n = '1;
   logic         busy_n = 1'b1;
   logic         lock_n = 1'b1;
   logic [N-1:0] grant_n;

   int n_checks = 0;
   int n_bad = 0;
   logic [N-1:0] exp_g = '0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   prio_lock_arbiter #(.N_MASTERS(N)) u0 (
      .clk(clk), .rst_n(rst_n), .req_n(req_n),
      .busy_n(busy_n), .lock_n(lock_n), .grant_n(grant_n)
   );

   function automatic logic [N-1:0] model(input logic [N-1:0] cur,
                                          input logic [N-1:0] rq,
                                          input logic free);
      logic [N-1:0] r;
      int holder;
      r = cur;
      if (free) begin
         for (int k = N-1; k >= 0; k--) if (rq[k]) r = (1 << k);
      end else begin
         holder = -1;
         for (int k = 0; k < N; k++) if (cur[k]) holder = k;
         for (int k = 0; k < N; k++) if (holder > k && rq[k]) r = '0;
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s grant_n=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic step(input logic [N-1:0] rq_n, input logic b_n, input logic l_n, input string tag);
      logic [N-1:0] nxt;
      @(negedge clk);
      req_n = rq_n; busy_n = b_n; lock_n = l_n;
      nxt = model(exp_g, ~rq_n, b_n & l_n);
      @(posedge clk);
      #1;
      exp_g = nxt;
      check(tag, grant_n, ~exp_g);
      n_checks++;
      if ($countones(~grant_n) > 1) begin
         n_bad++;
         $display("FAIL R2 grant_n=%b expected at most one low", grant_n);
      end
   endtask

   task automatic finish_up;
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_checks++;
      n_bad++;
      $display("FAIL watchdog grant_n=%b expected=run to end", grant_n);
      finish_up();
   end

   initial begin
      logic [N-1:0] r;
      logic bb, ll, fr, hp;
      string tag;
      int hold;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1 check("R1 in reset", grant_n, '1);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk) #1 check("R1 after reset", grant_n, '1);

      step(4'b1011, 1'b1, 1'b1, "R3 single request m2");
      step(4'b0000, 1'b1, 1'b1, "R3 all request m0 wins");
      step(4'b1111, 1'b1, 1'b1, "R4 park on m0");
      step(4'b0111, 1'b1, 1'b1, "R3 m3 alone");
      step(4'b0111, 1'b0, 1'b0, "R5 m3 locked");
      step(4'b0111, 1'b1, 1'b0, "R5 m3 locked, not busy");
      step(4'b1111, 1'b1, 1'b1, "R4 park on m3");
      step(4'b0111, 1'b0, 1'b0, "R5 m3 busy again");
      step(4'b1101, 1'b0, 1'b0, "R6 m1 asks during lock");
      step(4'b1101, 1'b1, 1'b0, "R6 still locked, none granted");
      step(4'b1001, 1'b1, 1'b1, "R7 lock released, m1 wins");
      step(4'b0101, 1'b0, 1'b0, "R8 m3 asks, m1 keeps");
      step(4'b0101, 1'b1, 1'b0, "R8 still locked");
      step(4'b0110, 1'b0, 1'b0, "R6 m0 outranks m1");
      step(4'b0110, 1'b1, 1'b1, "R7 m0 after release");

      for (int n = 0; n < 3000; n++) begin
         r  = N'($urandom);
         hold = $urandom_range(0, 3);
         bb = (hold == 0) ? 1'b0 : 1'b1;
         ll = (hold <= 1) ? 1'b0 : 1'b1;
         fr = bb & ll;
         hp = 1'b0;
         for (int j = 0; j < N; j++)
            for (int i = 0; i < j; i++)
               if (exp_g[j] && !r[i]) hp = 1'b1;
         if (fr && r != '1)      tag = "R3 random free";
         else if (fr)            tag = "R4 random idle";
         else if (hp)            tag = "R6 random outrank";
         else                    tag = "R5 random hold";
         step(r, bb, ll, tag);
      end

      @(negedge clk) rst_n = 1'b0;
      #1 check("R1 reset mid-run", grant_n, '1);
      finish_up();
   end

endmodule